// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with a free-running 32-bit counter and a two-step timeout. When the first timeout interval runs out, the block sends one interrupt pulse and sets a pending flag. Software answers by writing a one to that flag, which clears it. If the flag is still set when the next interval runs out, the block raises a system reset output. That output stays high until the block itself is reset.

The timeout length is 2^INTERVAL clock cycles. INTERVAL is a synthesis parameter, legal from 8 to 32. Expiry happens each time the low INTERVAL bits of the counter roll over.

A small register port controls the block:

- offset 0x0: the enable bit.
- offset 0x4: the pending flag, cleared by writing a one.
- offset 0x8: the live counter, read-only.

A build-time lock option, LOCK_ONCE, makes the enable bit impossible to clear once it has been set.

Top module: `wdt_dual_stage`

## Requirements
- R1: After the block reset, the interrupt and reset outputs are low, and the registers at 0x0, 0x4 and 0x8 all read zero.
- R2: While bit 0 of the control register (0x0) is zero, the counter is held at zero and reads 0 at 0x8. No interrupt and no reset occur, however long the block waits.
- R3: If enable is captured at clock edge T, the first expiry gives a one-cycle interrupt pulse after edge T+2^INTERVAL. It also sets the pending flag, which is bit 0 of 0x4.
- R4: A write with data bit 0 = 1 to 0x4 clears the pending flag. A write with data bit 0 = 0 leaves the flag unchanged.
- R5: An expiry that finds the pending flag already set raises the reset output at that expiry edge, together with the interrupt pulse. The reset output then stays high, even through clears and disables, until the block reset.
- R6: A clear of the pending flag captured at the same edge as an expiry loses: the flag ends up set.
- R7: Bit 0 of 0x0 reads back the enable state. Writing zero to it stops the watchdog.
- R8: With LOCK_ONCE=1, a write of zero to the enable bit after enabling is ignored. The enable bit still reads 1 and the counter keeps running.
- R9: A read of 0x8 returns the counter value before the capture edge, which is the number of edges since the enable edge, minus one. Read data is registered and appears the cycle after the address is presented.
- R10: While enabled, expiries repeat every 2^INTERVAL cycles. An interrupt pulse comes on each expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 1 | Write data; all writable fields are bit 0 |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| wdt_irq | output | 1 | One-cycle pulse on each expiry |
| wdt_rst | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach from the ports is a clear of the pending flag that lands on the very edge where the counter expires. The stimulus counts edges from the enable write and presents the clear one cycle before the predicted expiry. The bench then reads the flag back to confirm that the expiry won. Reaching the sticky reset requires a full second interval with the flag left uncleared. The bench therefore re-enables from a known edge and samples the reset output on both sides of the predicted rise.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h8;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int CNT_W    = 32,
  parameter int INTERVAL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [INTERVAL-1:0] ROLL = '1;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // carry out of bit INTERVAL-1 on the next increment
  assign expire = en && (cnt[INTERVAL-1:0] == ROLL);
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr_req,
  output logic state,
  output logic irq,
  output logic wrst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= 1'b0;
      irq   <= 1'b0;
      wrst  <= 1'b0;
    end else begin
      irq <= expire;
      if (expire) begin
        state <= 1'b1;          // expiry wins over a simultaneous clear
        if (state) wrst <= 1'b1;
      end else if (clr_req) begin
        state <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter bit LOCK_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  input  logic              state,
  input  logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              clr_req,
  output logic [CNT_W-1:0]  rdata
);
  localparam int PAD_W = CNT_W - 1;

  logic ctrl_wr;
  logic en_wr_ok;

  assign ctrl_wr = we && (addr == OFS_CTRL);
  assign clr_req = we && (addr == OFS_STAT) && wdata;

  generate
    if (LOCK_ONCE) begin : g_lock
      assign en_wr_ok = !en;      // once set, enable cannot be written
    end else begin : g_free
      assign en_wr_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                      en <= 1'b0;
    else if (ctrl_wr && en_wr_ok) en <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        OFS_CTRL: rdata <= {{PAD_W{1'b0}}, en};
        OFS_STAT: rdata <= {{PAD_W{1'b0}}, state};
        OFS_CNT:  rdata <= cnt;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int INTERVAL  = 8,
  parameter bit LOCK_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  logic             en_q;
  logic             clr_req;
  logic             state_q;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;

  wdt_timebase #(.CNT_W(CNT_W), .INTERVAL(INTERVAL)) u_tb (
    .clk(clk), .rst(rst), .en(en_q), .cnt(cnt_q), .expire(expire)
  );

  wdt_expiry u_exp (
    .clk(clk), .rst(rst), .expire(expire), .clr_req(clr_req),
    .state(state_q), .irq(wdt_irq), .wrst(wdt_rst)
  );

  wdt_regs #(.CNT_W(CNT_W), .LOCK_ONCE(LOCK_ONCE)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .state(state_q), .cnt(cnt_q), .en(en_q), .clr_req(clr_req),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/wdt_dual_stage_chk.sv
module wdt_dual_stage_chk #(
  parameter int CNT_W     = 32,
  parameter bit LOCK_ONCE = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             state,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             wrst
);
  a_r2_idle_no_irq: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
  a_r2_idle_cnt_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
  a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r3_irq_sets_state: assert property (@(posedge clk) disable iff (rst)
    irq |-> state);
  a_r5_rst_with_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(wrst) |-> irq);
  a_r5_rst_sticky: assert property (@(posedge clk) disable iff (rst)
    wrst |=> wrst);
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (LOCK_ONCE && en) |=> en);
endmodule

bind wdt_dual_stage wdt_dual_stage_chk #(.CNT_W(CNT_W), .LOCK_ONCE(LOCK_ONCE)) u_chk (
  .clk(clk), .rst(rst), .en(en_q), .state(state_q), .cnt(cnt_q),
  .irq(wdt_irq), .wrst(wdt_rst)
);

// File: tb/tb_wdt_dual_stage.sv
module tb_wdt_dual_stage;
  localparam int CNT_W = 32;
  localparam int INTERVAL = 8;
  localparam int PER = 1 << INTERVAL;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_CNT = 4'h8;

  logic clk = 1'b0, rst = 1'b1;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [3:0] addr = '0;
  logic wdata = 1'b0;
  logic [CNT_W-1:0] rdata0, rdata1;
  logic irq0, wrst0, irq1, wrst1;

  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_dual_stage #(.CNT_W(CNT_W), .INTERVAL(INTERVAL), .LOCK_ONCE(1'b0)) dut (
    .clk(clk), .rst(rst), .bus_we(we0), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata0), .wdt_irq(irq0), .wdt_rst(wrst0));

  wdt_dual_stage #(.CNT_W(CNT_W), .INTERVAL(INTERVAL), .LOCK_ONCE(1'b1)) dut_lock (
    .clk(clk), .rst(rst), .bus_we(we1), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata1), .wdt_irq(irq1), .wdt_rst(wrst1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit which, input logic [3:0] a, input logic d, output int cap);
    @(negedge clk);
    addr = a; wdata = d; we0 = !which; we1 = which;
    @(negedge clk);
    cap = cyc; we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d0, output logic [31:0] d1, output int cap);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d0 = rdata0; d1 = rdata1; cap = cyc;
  endtask

  // scoreboard monitor: each interrupt pulse must match the next expected edge
  always @(negedge clk) begin
    if (!rst && irq0) begin
      if (exp_q.size() == 0) chk("R2 R3 unexpected irq", cyc, 0);
      else chk("R3 R10 irq edge", cyc, exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d0, d1;
    int t, t2, t3, c, dummy;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    chk("R1 irq", irq0, 0);
    chk("R1 rst", wrst0, 0);
    rd(A_CTRL, d0, d1, c); chk("R1 ctrl", d0, 0);
    rd(A_STAT, d0, d1, c); chk("R1 stat", d0, 0);
    rd(A_CNT, d0, d1, c);  chk("R1 cnt", d0, 0);

    repeat (600) @(negedge clk);
    rd(A_CNT, d0, d1, c); chk("R2 cnt idle", d0, 0);
    chk("R2 rst idle", wrst0, 0);

    wr(0, A_CTRL, 1'b1, t);
    exp_q.push_back(t + PER);
    exp_q.push_back(t + 2 * PER);
    rd(A_CTRL, d0, d1, c); chk("R7 ctrl on", d0, 1);
    rd(A_CNT, d0, d1, c);  chk("R9 cnt", d0, c - 1 - t);

    while (cyc < t + PER + 4) @(negedge clk);
    rd(A_STAT, d0, d1, c); chk("R3 state set", d0, 1);
    wr(0, A_STAT, 1'b0, dummy);
    rd(A_STAT, d0, d1, c); chk("R4 write0 keeps", d0, 1);
    wr(0, A_STAT, 1'b1, dummy);
    rd(A_STAT, d0, d1, c); chk("R4 write1 clears", d0, 0);
    chk("R5 no rst after clear", wrst0, 0);

    // clear captured on the expiry edge t+2*PER
    while (cyc < t + 2 * PER - 1) @(negedge clk);
    addr = A_STAT; wdata = 1'b1; we0 = 1'b1;
    @(negedge clk);
    we0 = 1'b0;
    rd(A_STAT, d0, d1, c); chk("R6 expiry wins", d0, 1);
    chk("R6 no rst", wrst0, 0);

    wr(0, A_STAT, 1'b1, dummy);
    wr(0, A_CTRL, 1'b0, dummy);
    rd(A_CTRL, d0, d1, c); chk("R7 ctrl off", d0, 0);
    repeat (600) @(negedge clk);
    rd(A_CNT, d0, d1, c); chk("R2 cnt held", d0, 0);
    chk("R10 queue drained", exp_q.size(), 0);

    wr(0, A_CTRL, 1'b1, t2);
    exp_q.push_back(t2 + PER);
    exp_q.push_back(t2 + 2 * PER);
    while (cyc < t2 + 2 * PER - 1) @(negedge clk);
    chk("R5 rst before", wrst0, 0);
    @(negedge clk);
    chk("R5 rst rises", wrst0, 1);
    wr(0, A_STAT, 1'b1, dummy);
    wr(0, A_CTRL, 1'b0, dummy);
    repeat (300) @(negedge clk);
    chk("R5 rst sticky", wrst0, 1);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 rst cleared", wrst0, 0);
    rd(A_CTRL, d0, d1, c); chk("R1 ctrl after reset", d0, 0);

    wr(1, A_CTRL, 1'b1, t3);
    wr(1, A_CTRL, 1'b0, dummy);
    rd(A_CTRL, d0, d1, c); chk("R8 lock ctrl", d1, 1);
    repeat (20) @(negedge clk);
    rd(A_CNT, d0, d1, c); chk("R8 lock still counting", d1, c - 1 - t3);

    chk("R10 queue empty", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule